// File: doc/BRIEF.md
# Register-Mapped SPI Controller with Mode-Fault Detection

This block is a byte-wide SPI engine that a processor drives through three registers on a simple synchronous bus: control, status and data. Software selects master or slave operation, the SCK idle level, the sampling phase and, in master mode, the SCK divisor. Writing the data register loads the shift register. In master mode that write also starts an 8-bit exchange, MSB first. Reading the data register returns the last completed byte from a one-deep receive buffer.

A transfer-complete flag raises the interrupt output when interrupts are enabled. The flag clears when the interrupt is acknowledged, or when software reads status while a flag is set and then touches the data register. A data write during an exchange raises a collision flag and leaves the byte in flight untouched. A low slave-select seen while in master mode is a mode fault: hardware drops to slave mode and raises the transfer-complete flag.

The engine is a three-state machine. `ST_IDLE` has no exchange. In `ST_LEAD` SCK sits at its idle level and the leading edge is awaited. In `ST_TRAIL` SCK is at its active level and the trailing edge is awaited. The transitions are:
- IDLE→LEAD on a master start, or in slave mode when slave-select goes low.
- LEAD→TRAIL on a leading edge.
- TRAIL→LEAD on a trailing edge that is not the last one.
- TRAIL→IDLE on the eighth trailing edge in master mode.
- Any state→IDLE on a mode fault, or in slave mode when slave-select goes high.

Top module: `spi_regctl`

## Requirements
- R1: Control bit 1 selects master mode (1) or slave mode (0). In master mode `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0. In slave mode `sck_oe` and `mosi_oe` are 0.
- R2: When `ss_n_i` is low while master mode is selected, hardware clears control bit 1 and sets status bit 7. The mode stays slave until software writes bit 1 again.
- R3: With no exchange in progress, `sck_o` equals control bit 2 (1 means SCK idles high).
- R4: In master mode, control bits 5:4 set the SCK period in clock cycles: 00 gives 4, 01 gives 16, 10 gives 64 and 11 gives 128, each half period being equal. These bits have no effect in slave mode.
- R5: Status bit 7 sets when a full byte completes. `irq` equals status bit 7 AND control bit 0.
- R6: A one-cycle pulse on `irq_ack` clears status bit 7.
- R7: Status bit 6 sets when the data register is written during an exchange. The byte being shifted is not altered by that write.
- R8: Reading status while bit 7 or bit 6 is set, followed by a read or write of the data register, clears both bits. A data access without that prior status read leaves them set.
- R9: The registers sit at offset 0xD (control), 0xE (status) and 0xF (data). Status bits 5:0 and control bits 7:6 read as 0. After reset, control and status read 0x00.
- R10: A data-register write loads the transmit byte, and in master mode it starts the exchange. A data-register read returns the receive buffer, which changes only when all 8 bits have completed.
- R11: Data is sent and received MSB first. With control bit 3 = 0, the input is sampled on the leading SCK edge and the output shifts on the trailing edge. With bit 3 = 1, the output changes on the leading edge and the input is sampled on the trailing edge.
- R12: In slave mode a high `ss_n_i` resets the bit counter and drives `miso_oe` low, so a partial byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Transfer-complete interrupt |
| irq_ack | input | 1 | Interrupt acknowledge, clears status bit 7 |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data out enable |
| mosi_i | input | 1 | Master data in, used in slave mode |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data out enable |
| miso_i | input | 1 | Slave data in, used in master mode |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The hardest case to reach is a data write that lands in the middle of a master exchange. The bench has to hit it without disturbing the status flags it will inspect afterwards. The stimulus selects the slowest divisor, and a bench-side slave model runs in parallel with the bus thread. The bus thread then writes a second byte a fixed number of cycles after the start. It does no status polling until the exchange has certainly finished, because a status read would arm the clearing sequence.

The partial-byte discard is reached the same way. The bench drives only three slave SCK cycles, raises slave-select, reloads the data register and then sends a whole byte.

// File: rtl/spi_regctl_pkg.sv
package spi_regctl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic [1:0] rate;
        logic       cpha;
        logic       cpol;
        logic       master;
        logic       ie;
    } ctrl_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int BASE_HALF = 2,
    localparam int CNT_W    = $clog2(BASE_HALF << 5) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    int               shamt;

    always_comb begin
        shamt = (rate == 2'd3) ? 5 : 2 * int'(rate);
        lim   = CNT_W'((BASE_HALF << shamt) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == lim) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == lim);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_regctl_pkg::*;
#(
    parameter int  BITS = BYTE_W,
    localparam int CW   = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    input  logic            abort,
    input  logic            tick,
    input  logic            sck_s,
    input  logic            mosi_s,
    input  logic            ss_s,
    input  logic            miso_i,
    output xfer_state_e     state,
    output logic            busy,
    output logic            sck_o,
    output logic            out_bit,
    output logic            done,
    output logic [BITS-1:0] shreg,
    output logic [CW-1:0]   bit_cnt
);
    xfer_state_e nxt;
    logic        sck_prev, obit, samp;
    logic        lead_ev, trail_ev, in_bit, s_rise, s_fall;
    logic        last_bit;

    assign s_rise   = sck_s && !sck_prev;
    assign s_fall   = !sck_s && sck_prev;
    assign in_bit   = master ? miso_i : mosi_s;
    assign last_bit = (bit_cnt == CW'(BITS - 1));

    always_comb begin
        if (master) begin
            lead_ev  = (state == ST_LEAD) && tick;
            trail_ev = (state == ST_TRAIL) && tick;
        end else begin
            lead_ev  = !ss_s && (cpol ? s_fall : s_rise);
            trail_ev = !ss_s && (cpol ? s_rise : s_fall);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (master ? load : !ss_s) nxt = ST_LEAD;
            ST_LEAD:  if (!master && ss_s) nxt = ST_IDLE;
                      else if (lead_ev)    nxt = ST_TRAIL;
            ST_TRAIL: if (!master && ss_s) nxt = ST_IDLE;
                      else if (trail_ev)   nxt = (master && last_bit) ? ST_IDLE : ST_LEAD;
            default:  nxt = ST_IDLE;
        endcase
        if (abort) nxt = ST_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            obit     <= 1'b0;
            samp     <= 1'b0;
            done     <= 1'b0;
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            done     <= 1'b0;
            if (abort) begin
                bit_cnt <= '0;
            end else if (load) begin
                shreg   <= load_data;
                obit    <= load_data[BITS-1];
                bit_cnt <= '0;
            end else if (!master && ss_s) begin
                bit_cnt <= '0;
            end else begin
                if (lead_ev) begin
                    if (cpha) begin
                        obit  <= shreg[BITS-1];
                        shreg <= {shreg[BITS-2:0], 1'b0};
                    end else begin
                        samp  <= in_bit;
                    end
                end
                if (trail_ev) begin
                    if (cpha) shreg[0] <= in_bit;
                    else      shreg    <= {shreg[BITS-2:0], samp};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) done <= 1'b1;
                end
            end
        end
    end

    assign busy    = master ? (state != ST_IDLE) : ((state == ST_TRAIL) || (bit_cnt != '0));
    assign sck_o   = cpol ^ (master && (state == ST_TRAIL));
    assign out_bit = cpha ? obit : shreg[BITS-1];
endmodule

// File: rtl/spi_regctl.sv
module spi_regctl
    import spi_regctl_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 4'hD,
    parameter logic [ADDR_W-1:0] STAT_OFS = 4'hE,
    parameter logic [ADDR_W-1:0] DATA_OFS = 4'hF,
    parameter int              BASE_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    input  logic              irq_ack,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              miso_i,
    input  logic              ss_n_i
);
    localparam int CW = $clog2(BYTE_W);

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] rxbuf, shreg;
    logic              flag_done, flag_wcol, arm;
    logic              ss_s, sck_s, mosi_s;
    logic              sel_ctrl, sel_stat, sel_data;
    logic              data_wr, data_acc, clr, mfault, load, busy, done_p, tick, out_bit;
    logic [CW-1:0]     bit_cnt;
    xfer_state_e       st;

    spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ss_n_i, sck_i, mosi_i}),
        .q({ss_s, sck_s, mosi_s})
    );

    assign sel_ctrl = (bus_addr == CTRL_OFS);
    assign sel_stat = (bus_addr == STAT_OFS);
    assign sel_data = (bus_addr == DATA_OFS);
    assign data_wr  = bus_wr && sel_data;
    assign data_acc = (bus_wr || bus_rd) && sel_data;
    assign clr      = arm && data_acc;
    assign mfault   = ctrl_q.master && !ss_s;
    assign load     = data_wr && !busy;

    spi_clkdiv #(.BASE_HALF(BASE_HALF)) u_div (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl_q.master && (st != ST_IDLE)),
        .rate(ctrl_q.rate),
        .tick(tick)
    );

    spi_shifter #(.BITS(BYTE_W)) u_shf (
        .clk(clk), .rst_n(rst_n),
        .master(ctrl_q.master), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
        .load(load), .load_data(bus_wdata), .abort(mfault), .tick(tick),
        .sck_s(sck_s), .mosi_s(mosi_s), .ss_s(ss_s), .miso_i(miso_i),
        .state(st), .busy(busy), .sck_o(sck_o), .out_bit(out_bit),
        .done(done_p), .shreg(shreg), .bit_cnt(bit_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            rxbuf     <= '0;
            flag_done <= 1'b0;
            flag_wcol <= 1'b0;
            arm       <= 1'b0;
        end else begin
            if (bus_wr && sel_ctrl) ctrl_q <= ctrl_t'(bus_wdata[5:0]);
            if (mfault)             ctrl_q.master <= 1'b0;

            if (done_p) rxbuf <= shreg;

            if (done_p || mfault)     flag_done <= 1'b1;
            else if (irq_ack || clr)  flag_done <= 1'b0;

            if (data_wr && busy) flag_wcol <= 1'b1;
            else if (clr)        flag_wcol <= 1'b0;

            if (bus_rd && sel_stat && (flag_done || flag_wcol)) arm <= 1'b1;
            else if (data_acc)                                  arm <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)      bus_rdata = {2'b00, ctrl_q};
        else if (sel_stat) bus_rdata = {flag_done, flag_wcol, 6'b000000};
        else if (sel_data) bus_rdata = rxbuf;
    end

    assign irq     = flag_done && ctrl_q.ie;
    assign sck_oe  = ctrl_q.master;
    assign mosi_oe = ctrl_q.master;
    assign mosi_o  = out_bit;
    assign miso_o  = out_bit;
    assign miso_oe = !ctrl_q.master && !ss_s;
endmodule

// File: rtl/spi_regctl_chk.sv
module spi_regctl_chk
    import spi_regctl_pkg::*;
#(
    parameter int CW = 3
) (
    input logic        clk,
    input logic        rst_n,
    input ctrl_t       ctrl_q,
    input xfer_state_e state,
    input logic        busy,
    input logic [CW-1:0] bit_cnt,
    input logic        ss_s,
    input logic        sck_o,
    input logic        irq,
    input logic        flag_done,
    input logic        flag_wcol,
    input logic        done_p,
    input logic        mfault,
    input logic        data_wr,
    input logic [7:0]  rxbuf
);
    AST_MFAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.master && !ss_s) |=> !ctrl_q.master); // R2

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.master && state == ST_IDLE) |-> (sck_o == ctrl_q.cpol)); // R3

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_done) |-> $past(done_p || mfault)); // R5

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_done); // R5

    AST_WCOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_wcol) |-> $past(data_wr && busy)); // R7

    AST_RXBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_p |=> $stable(rxbuf)); // R10

    AST_SS_CNT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.master && ss_s) |=> (bit_cnt == '0)); // R12
endmodule

bind spi_regctl spi_regctl_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .state(st), .busy(busy),
    .bit_cnt(bit_cnt), .ss_s(ss_s), .sck_o(sck_o), .irq(irq),
    .flag_done(flag_done), .flag_wcol(flag_wcol), .done_p(done_p),
    .mfault(mfault), .data_wr(data_wr), .rxbuf(rxbuf)
);

// File: tb/spi_regctl_bench.sv
module spi_regctl_bench;
    localparam logic [3:0] A_CTRL = 4'hD;
    localparam logic [3:0] A_STAT = 4'hE;
    localparam logic [3:0] A_DATA = 4'hF;
    localparam int SH = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, irq_ack = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

    int n_tests = 0, n_fail = 0;
    logic [7:0] m_rx;
    int m_edges, m_hpmin, m_hpmax;
    logic [7:0] last_rx;

    always #4 clk = ~clk;

    spi_regctl u_spi_regctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .irq_ack(irq_ack),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_done(output logic [7:0] st);
        st = '0;
        for (int k = 0; k < 4000; k++) begin
            bus_read(A_STAT, st);
            if (st[7]) break;
        end
    endtask

    // bench-side slave answering the DUT master
    task automatic slave_model(input logic cpol, input logic cpha, input logic [7:0] tx);
        logic prev;
        int idx, c, last;
        prev = sck_o; idx = 0; c = 0; last = 0;
        m_rx = '0; m_edges = 0; m_hpmin = 1000000; m_hpmax = 0;
        if (!cpha) miso_i = tx[7];
        while (m_edges < 16 && c < 5000) begin
            @(negedge clk); c++;
            if (sck_o !== prev) begin
                if (m_edges > 0) begin
                    if (c - last < m_hpmin) m_hpmin = c - last;
                    if (c - last > m_hpmax) m_hpmax = c - last;
                end
                last = c; m_edges++;
                if (sck_o != cpol) begin
                    if (!cpha) m_rx = {m_rx[6:0], mosi_o};
                    else       miso_i = tx[7-idx];
                end else begin
                    if (!cpha) begin idx++; if (idx < 8) miso_i = tx[7-idx]; end
                    else begin m_rx = {m_rx[6:0], mosi_o}; idx++; end
                end
            end
            prev = sck_o;
        end
    endtask

    // bench drives the DUT slave as a master
    task automatic master_drive(input logic cpol, input logic cpha, input logic [7:0] b,
                                input int nbits, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi_i = b[7-i];
                repeat (SH) @(negedge clk);
                got = {got[6:0], miso_o};
                sck_i = ~cpol;
                repeat (SH) @(negedge clk);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol; mosi_i = b[7-i];
                repeat (SH) @(negedge clk);
                got = {got[6:0], miso_o};
                sck_i = cpol;
                repeat (SH) @(negedge clk);
            end
        end
        repeat (SH) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R10 watchdog: actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

    initial begin
        logic [7:0] d, st, got, txm, txd;
        int half;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 reset values and read-as-zero bits
        bus_read(A_CTRL, d); chk("R9 ctrl reset", d, 8'h00);
        bus_read(A_STAT, d); chk("R9 status reset", d, 8'h00);
        chk("R5 irq reset", {7'b0, irq}, 8'h00);
        bus_write(A_CTRL, 8'hFF);
        bus_read(A_CTRL, d); chk("R9 ctrl bits 7:6 zero", d, 8'h3F);
        bus_write(A_CTRL, 8'h00);
        last_rx = 8'h00;

        // master sweep over polarity, phase and rate: R1 R3 R4 R5 R8 R10 R11
        for (int m = 0; m < 16; m++) begin
            logic cp, ch;
            logic [1:0] rt;
            cp = m[0]; ch = m[1]; rt = m[3:2];
            half = ((rt == 2'd3) ? 128 : (4 << (2 * rt))) / 2;
            txm = 8'h5A ^ 8'(m * 37);
            txd = 8'hC3 ^ 8'(m * 11);
            bus_write(A_CTRL, {2'b00, rt, ch, cp, 1'b1, 1'b0});
            repeat (3) @(negedge clk);
            chk("R3 sck idle level", {7'b0, sck_o}, {7'b0, cp});
            chk("R1 master oe", {5'b0, sck_oe, mosi_oe, miso_oe}, 8'h06);
            fork
                slave_model(cp, ch, txm);
                begin bus_write(A_DATA, txd); wait_done(st); end
            join
            chk("R5 done flag", st, 8'h80);
            chk("R5 irq masked", {7'b0, irq}, 8'h00);
            chk("R11 slave got master byte", m_rx, txd);
            chk("R4 edge count", 8'(m_edges), 8'd16);
            chk("R4 min half period", 8'(m_hpmin), 8'(half));
            chk("R4 max half period", 8'(m_hpmax), 8'(half));
            bus_read(A_DATA, d); chk("R10 rx buffer", d, txm);
            bus_read(A_STAT, d); chk("R8 cleared by sequence", d, 8'h00);
            last_rx = txm;
        end

        // R8 data access without prior status read keeps flag
        bus_write(A_CTRL, 8'h02);
        fork
            slave_model(1'b0, 1'b0, 8'h81);
            begin bus_write(A_DATA, 8'h18); repeat (60) @(negedge clk); end
        join
        bus_read(A_DATA, d); chk("R10 rx after byte", d, 8'h81);
        bus_read(A_STAT, d); chk("R8 flag kept without arm", d, 8'h80);
        bus_read(A_DATA, d);
        bus_read(A_STAT, d); chk("R8 flag cleared after arm", d, 8'h00);
        last_rx = 8'h81;

        // R7 write collision, R10 buffer not live during transfer
        bus_write(A_CTRL, 8'h32);
        fork
            slave_model(1'b0, 1'b0, 8'h3C);
            begin
                bus_write(A_DATA, 8'hA7);
                repeat (300) @(negedge clk);
                bus_read(A_DATA, d); chk("R10 buffer stable mid-transfer", d, last_rx);
                bus_write(A_DATA, 8'h11);
                repeat (1100) @(negedge clk);
            end
        join
        chk("R7 shifted byte unchanged", m_rx, 8'hA7);
        bus_read(A_STAT, d); chk("R7 collision flag", d, 8'hC0);
        bus_read(A_DATA, d); chk("R10 received after collision", d, 8'h3C);
        bus_read(A_STAT, d); chk("R8 both flags cleared", d, 8'h00);

        // R5 R6 interrupt and acknowledge
        bus_write(A_CTRL, 8'h03);
        fork
            slave_model(1'b0, 1'b0, 8'hE1);
            begin bus_write(A_DATA, 8'h7E); repeat (60) @(negedge clk); end
        join
        chk("R5 irq asserted", {7'b0, irq}, 8'h01);
        @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R6 irq after ack", {7'b0, irq}, 8'h00);
        bus_read(A_STAT, d); chk("R6 flag after ack", d, 8'h00);

        // R2 mode fault
        bus_write(A_CTRL, 8'h02);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        bus_read(A_CTRL, d); chk("R2 master bit cleared", d, 8'h00);
        bus_read(A_STAT, d); chk("R2 flag on mode fault", d, 8'h80);
        ss_n_i = 1'b1;
        bus_read(A_DATA, d);
        bus_read(A_STAT, d); chk("R8 clear after fault", d, 8'h00);

        // slave sweep: R1 R4 R11 R12
        for (int m = 0; m < 4; m++) begin
            logic cp, ch;
            cp = m[0]; ch = m[1];
            txm = 8'h96 ^ 8'(m * 29);
            txd = 8'h4B ^ 8'(m * 53);
            sck_i = cp;
            bus_write(A_CTRL, {2'b00, 2'(m), ch, cp, 1'b0, 1'b0});
            bus_write(A_DATA, txm);
            repeat (4) @(negedge clk);
            chk("R12 miso hi-z when deselected", {7'b0, miso_oe}, 8'h00);
            chk("R1 slave oe", {6'b0, sck_oe, mosi_oe}, 8'h00);
            ss_n_i = 1'b0;
            repeat (4) @(negedge clk);
            chk("R12 miso driven when selected", {7'b0, miso_oe}, 8'h01);
            master_drive(cp, ch, txd, 8, got);
            ss_n_i = 1'b1;
            wait_done(st);
            chk("R5 slave done flag", st, 8'h80);
            chk("R11 slave sent byte", got, txm);
            bus_read(A_DATA, d); chk("R11 slave received byte", d, txd);
        end

        // R12 partial byte discarded on deselect
        sck_i = 1'b0;
        bus_write(A_CTRL, 8'h00);
        bus_write(A_DATA, 8'hF0);
        ss_n_i = 1'b0; repeat (4) @(negedge clk);
        master_drive(1'b0, 1'b0, 8'hFF, 3, got);
        ss_n_i = 1'b1; repeat (6) @(negedge clk);
        bus_read(A_STAT, d); chk("R12 no done after partial", d, 8'h00);
        bus_write(A_DATA, 8'h2D);
        bus_read(A_STAT, d); chk("R12 reload without collision", d, 8'h00);
        ss_n_i = 1'b0; repeat (4) @(negedge clk);
        master_drive(1'b0, 1'b0, 8'h69, 8, got);
        ss_n_i = 1'b1;
        wait_done(st);
        chk("R12 full byte sent after reset", got, 8'h2D);
        bus_read(A_DATA, d); chk("R12 full byte received", d, 8'h69);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule